// File: doc/BRIEF.md
# Converter Sample Byte Serializer

This block takes each 16-bit sample from the converter and puts it onto an 8-bit output bus, one piece per converter clock. A format select picks one of three layouts. The first layout sends the sample as two bytes. The second sends only the upper byte. The third sends four nibbles, and it is available only when the wide-sample flag is set. Pieces always go out most significant first. A phase marker flags the first piece of every sample, so a receiver can re-align.

A live invert control complements every data bit on the bus. The bus drives only when two conditions both hold: the external active-low enable pin is low, and the software disable bit is clear. Any other combination releases the bus. Tri-state is modelled as data plus a per-bit drive enable.

A synchronous software reset command returns the block to its reset state. The sequencer is a state machine with these states:

- `ST_IDLE`: no sample in flight.
- `ST_BYTE_HI`, then `ST_BYTE_LO`: the two-byte layout.
- `ST_MSB_ONLY`: the upper-byte-only layout.
- `ST_NIB3`, `ST_NIB2`, `ST_NIB1`, `ST_NIB0`: the nibble layout, in that order.

Transitions:

- From any state, a soft reset goes to `ST_IDLE`.
- From any state, a valid strobe goes to the first state of the selected layout. This is the start or restart transition.
- Otherwise, `ST_BYTE_HI`→`ST_BYTE_LO`, `ST_NIB3`→`ST_NIB2`→`ST_NIB1`→`ST_NIB0`, and the last piece of each layout (`ST_BYTE_LO`, `ST_MSB_ONLY`, `ST_NIB0`) goes to `ST_IDLE`.

Top module: `adc_word_fmt`

## Requirements
- R1: After `rst_n` low, the block is idle: `first_phase`=0 and `bus_dat`=8'h00 when `inv_en`=0.
- R2: With `fmt_sel[0]`=0 (either value of bit 1), a sample captured at the clock edge where `smp_valid`=1 appears as its bits 15:8 in the next cycle and its bits 7:0 in the cycle after that.
- R3: With `fmt_sel`=2'b01, only bits 15:8 of the sample appear, for a single cycle after capture.
- R4: With `fmt_sel`=2'b11 and `wide_mode`=1, the sample appears as four nibbles on `bus_dat[3:0]` in four successive cycles. The order is bits 15:12, then 11:8, then 7:4, then 3:0. `bus_dat[7:4]` is 0 before inversion.
- R5: With `fmt_sel`=2'b11 and `wide_mode`=0, the block uses the two-byte layout of R2.
- R6: When `inv_en`=1, all 8 `bus_dat` bits are complemented in the same cycle. This covers idle and the upper nibble bits.
- R7: All 8 `bus_drv` bits are 1 exactly when `ext_oe_n`=0 and `sw_off`=0, and are 0 otherwise. This follows the pins in the same cycle.
- R8: `first_phase` is 1 exactly in the cycle carrying the first piece of a sample, and 0 otherwise.
- R9: A new `smp_valid` during a sequence abandons it and starts the new sample from its first piece in the next cycle.
- R10: Changes to `fmt_sel` or `wide_mode` after the capture edge do not alter the sample in flight.
- R11: In the cycle after the last piece, the block is idle with `bus_dat`=8'h00 before inversion.
- R12: `soft_rst`=1 at an edge sends the block idle in the next cycle, with stored sample cleared. It has priority over `smp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous software reset command |
| smp_data | input | 16 | Converted sample word |
| smp_valid | input | 1 | Sample strobe, one cycle |
| fmt_sel | input | 2 | Output layout select |
| wide_mode | input | 1 | Wide-sample flag, permits the nibble layout |
| inv_en | input | 1 | Invert all output data bits |
| sw_off | input | 1 | Software output disable |
| ext_oe_n | input | 1 | External active-low output enable |
| bus_dat | output | 8 | Output data bus value |
| bus_drv | output | 8 | Per-bit drive enable (0 = high impedance) |
| first_phase | output | 1 | Marks the first piece of a sample |

## Verification
The first piece of a sample is due one cycle after the edge that sees `smp_valid`. Each further piece follows one cycle later, and idle comes one cycle after the last piece. Inversion and drive enable take effect in the same cycle as their inputs change.

The bench drives inputs on the falling edge and samples on the next falling edge. That puts every check half a clock after the edge that should have produced the value. Pieces are checked at consecutive falling edges after the strobe.

// File: rtl/adc_word_fmt_pkg.sv
package adc_word_fmt_pkg;
    parameter int WORD_W = 16;
    parameter int BUS_W  = 8;
    parameter int NIB_W  = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BYTE_HI,
        ST_BYTE_LO,
        ST_MSB_ONLY,
        ST_NIB3,
        ST_NIB2,
        ST_NIB1,
        ST_NIB0
    } fmt_state_t;

    // Layout select codes
    localparam logic [1:0] FMT_MSB = 2'b01;
    localparam logic [1:0] FMT_NIB = 2'b11;
endpackage

// File: rtl/fmt_seq.sv
module fmt_seq
    import adc_word_fmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              smp_valid,
    input  logic [WORD_W-1:0] smp_data,
    input  logic [1:0]        fmt_sel,
    input  logic              wide_mode,
    output fmt_state_t        state,
    output logic [WORD_W-1:0] word_q
);
    fmt_state_t state_nx;
    fmt_state_t first_st;

    // First state of the selected layout
    always_comb begin
        if (fmt_sel == FMT_MSB)
            first_st = ST_MSB_ONLY;
        else if (fmt_sel == FMT_NIB && wide_mode)
            first_st = ST_NIB3;
        else
            first_st = ST_BYTE_HI;
    end

    always_comb begin
        state_nx = ST_IDLE;
        if (soft_rst) begin
            state_nx = ST_IDLE;
        end else if (smp_valid) begin
            state_nx = first_st;
        end else begin
            unique case (state)
                ST_IDLE:     state_nx = ST_IDLE;
                ST_BYTE_HI:  state_nx = ST_BYTE_LO;
                ST_BYTE_LO:  state_nx = ST_IDLE;
                ST_MSB_ONLY: state_nx = ST_IDLE;
                ST_NIB3:     state_nx = ST_NIB2;
                ST_NIB2:     state_nx = ST_NIB1;
                ST_NIB1:     state_nx = ST_NIB0;
                ST_NIB0:     state_nx = ST_IDLE;
                default:     state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            word_q <= '0;
        end else begin
            state <= state_nx;
            if (soft_rst)
                word_q <= '0;
            else if (smp_valid)
                word_q <= smp_data;
        end
    end

    AST_SOFT_RST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (state == ST_IDLE && word_q == '0)); // R12
    AST_HI_THEN_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BYTE_HI && !smp_valid && !soft_rst) |=> (state == ST_BYTE_LO)); // R2
    AST_NIB_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !soft_rst && fmt_sel == FMT_NIB && !wide_mode) |=> (state == ST_BYTE_HI)); // R5
    AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_valid && !soft_rst) |=> $stable(word_q)); // R10
    AST_MSB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MSB_ONLY && !smp_valid && !soft_rst) |=> (state == ST_IDLE)); // R3
endmodule

// File: rtl/fmt_mux.sv
module fmt_mux
    import adc_word_fmt_pkg::*;
(
    input  fmt_state_t        state,
    input  logic [WORD_W-1:0] word_q,
    input  logic              inv_en,
    output logic [BUS_W-1:0]  bus_dat,
    output logic              first_phase
);
    localparam int PAD_W = BUS_W - NIB_W;

    logic [BUS_W-1:0] raw;

    always_comb begin
        raw         = '0;
        first_phase = 1'b0;
        unique case (state)
            ST_IDLE:     raw = '0;
            ST_BYTE_HI:  begin raw = word_q[WORD_W-1 -: BUS_W]; first_phase = 1'b1; end
            ST_BYTE_LO:  raw = word_q[BUS_W-1:0];
            ST_MSB_ONLY: begin raw = word_q[WORD_W-1 -: BUS_W]; first_phase = 1'b1; end
            ST_NIB3:     begin raw = {{PAD_W{1'b0}}, word_q[4*NIB_W-1 -: NIB_W]}; first_phase = 1'b1; end
            ST_NIB2:     raw = {{PAD_W{1'b0}}, word_q[3*NIB_W-1 -: NIB_W]};
            ST_NIB1:     raw = {{PAD_W{1'b0}}, word_q[2*NIB_W-1 -: NIB_W]};
            ST_NIB0:     raw = {{PAD_W{1'b0}}, word_q[NIB_W-1:0]};
            default:     raw = '0;
        endcase
    end

    assign bus_dat = raw ^ {BUS_W{inv_en}};
endmodule

// File: rtl/fmt_drive.sv
module fmt_drive
    import adc_word_fmt_pkg::*;
(
    input  logic             ext_oe_n,
    input  logic             sw_off,
    output logic [BUS_W-1:0] bus_drv
);
    logic allow;
    assign allow = ~ext_oe_n & ~sw_off;

    for (genvar b = 0; b < BUS_W; b++) begin : g_bit
        assign bus_drv[b] = allow;
    end
endmodule

// File: rtl/adc_word_fmt.sv
module adc_word_fmt
    import adc_word_fmt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        soft_rst,
    input  logic [15:0] smp_data,
    input  logic        smp_valid,
    input  logic [1:0]  fmt_sel,
    input  logic        wide_mode,
    input  logic        inv_en,
    input  logic        sw_off,
    input  logic        ext_oe_n,
    output logic [7:0]  bus_dat,
    output logic [7:0]  bus_drv,
    output logic        first_phase
);
    fmt_state_t        state;
    logic [WORD_W-1:0] word_q;

    fmt_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .fmt_sel   (fmt_sel),
        .wide_mode (wide_mode),
        .state     (state),
        .word_q    (word_q)
    );

    fmt_mux u_mux (
        .state       (state),
        .word_q      (word_q),
        .inv_en      (inv_en),
        .bus_dat     (bus_dat),
        .first_phase (first_phase)
    );

    fmt_drive u_drv (
        .ext_oe_n (ext_oe_n),
        .sw_off   (sw_off),
        .bus_drv  (bus_drv)
    );

    AST_PHASE_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !soft_rst) |=> first_phase); // R8
    AST_DRV_NEEDS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (|bus_drv) |-> (!ext_oe_n && !sw_off)); // R7
    AST_NIB_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state inside {ST_NIB3, ST_NIB2, ST_NIB1, ST_NIB0} && !inv_en) |-> (bus_dat[7:4] == 4'h0)); // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!first_phase && bus_dat == {8{inv_en}})); // R11
endmodule

// File: tb/sim_adc_word_fmt.sv
module sim_adc_word_fmt;
    localparam time CLK_PER = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic [15:0] smp_data = '0;
    logic        smp_valid = 1'b0;
    logic [1:0]  fmt_sel = '0;
    logic        wide_mode = 1'b0;
    logic        inv_en = 1'b0;
    logic        sw_off = 1'b0;
    logic        ext_oe_n = 1'b0;
    logic [7:0]  bus_dat;
    logic [7:0]  bus_drv;
    logic        first_phase;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    adc_word_fmt u0 (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .smp_data(smp_data),
        .smp_valid(smp_valid), .fmt_sel(fmt_sel), .wide_mode(wide_mode),
        .inv_en(inv_en), .sw_off(sw_off), .ext_oe_n(ext_oe_n),
        .bus_dat(bus_dat), .bus_drv(bus_drv), .first_phase(first_phase)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Sends one sample; then scrambles layout inputs (R10) and checks each piece
    task automatic send(input logic [15:0] w, input logic [1:0] f, input logic wd, input logic iv);
        logic [7:0] m;
        int n;
        logic [7:0] exp_p [4];
        m = {8{iv}};
        if (f == 2'b01) begin
            n = 1; exp_p[0] = w[15:8];
        end else if (f == 2'b11 && wd) begin
            n = 4;
            exp_p[0] = {4'h0, w[15:12]}; exp_p[1] = {4'h0, w[11:8]};
            exp_p[2] = {4'h0, w[7:4]};   exp_p[3] = {4'h0, w[3:0]};
        end else begin
            n = 2; exp_p[0] = w[15:8]; exp_p[1] = w[7:0];
        end
        smp_data = w; fmt_sel = f; wide_mode = wd; inv_en = iv; smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
        fmt_sel = ~f; wide_mode = ~wd; smp_data = ~w;
        for (int k = 0; k < n; k++) begin
            chk(f == 2'b01 ? "R3 piece" : (n == 4 ? "R4 nibble" : (f == 2'b11 ? "R5 fallback" : "R2 byte")),
                bus_dat, exp_p[k] ^ m);
            chk("R8 phase", {7'b0, first_phase}, {7'b0, k == 0});
            @(negedge clk);
        end
        chk("R11 idle data", bus_dat, m);
        chk("R11 idle phase", {7'b0, first_phase}, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset data", bus_dat, 8'h00);
        chk("R1 reset phase", {7'b0, first_phase}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        // R6 idle inversion is same-cycle
        inv_en = 1'b1; #1;
        chk("R6 idle invert", bus_dat, 8'hFF);
        inv_en = 1'b0;

        // Sweep layouts, flag, inversion, words (R2 R3 R4 R5 R6 R10)
        for (int f = 0; f < 4; f++)
            for (int wd = 0; wd < 2; wd++)
                for (int iv = 0; iv < 2; iv++)
                    for (int k = 0; k < 4; k++)
                        send(16'(16'hA5C3 ^ (k * 16'h3B29)), 2'(f), 1'(wd), 1'(iv));

        // R7 drive enable sweep
        for (int c = 0; c < 4; c++) begin
            ext_oe_n = c[0]; sw_off = c[1]; #1;
            chk("R7 drive", bus_drv, (c == 0) ? 8'hFF : 8'h00);
        end
        ext_oe_n = 1'b0; sw_off = 1'b0;
        @(negedge clk);

        // R9 restart mid-sequence
        inv_en = 1'b0; fmt_sel = 2'b00; wide_mode = 1'b0;
        smp_data = 16'h1234; smp_valid = 1'b1;
        @(negedge clk);
        chk("R9 first of A", bus_dat, 8'h12);
        smp_data = 16'hBEEF;
        @(negedge clk);
        smp_valid = 1'b0;
        chk("R9 restart hi", bus_dat, 8'hBE);
        chk("R9 restart phase", {7'b0, first_phase}, 8'h01);
        @(negedge clk);
        chk("R9 restart lo", bus_dat, 8'hEF);
        @(negedge clk);

        // R12 soft reset mid-nibble, priority over valid
        fmt_sel = 2'b11; wide_mode = 1'b1; smp_data = 16'hC71D; smp_valid = 1'b1;
        @(negedge clk);
        chk("R12 pre nibble", bus_dat, 8'h0C);
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0; smp_valid = 1'b0;
        chk("R12 idle data", bus_dat, 8'h00);
        chk("R12 idle phase", {7'b0, first_phase}, 8'h00);
        @(negedge clk);
        chk("R12 stays idle", bus_dat, 8'h00);

        // R1 asynchronous reset mid-sequence
        fmt_sel = 2'b00; smp_data = 16'h5A5A; smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
        rst_n = 1'b0; #1;
        chk("R1 async reset", bus_dat, 8'h00);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule